// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

Two 8-line priority interrupt controllers of the classic personal-computer kind are joined here as a primary and a secondary, giving 16 request lines and one interrupt output toward the CPU. The secondary's request flag feeds line 2 of the primary, and that line is reserved for this link. When the CPU acknowledges, the block first asks the primary for a vector. If that vector points at the cascade line, the block asks the secondary as well and returns the secondary's vector.

Software reaches both controllers through a small byte-wide port bus. Each controller has a command port and a data port, and each has an edge/level select register. A 16-bit write to either command port carries one command byte for each controller. Reads, writes and acknowledges are answered one clock later.

Top module: `dual_intc`

## Requirements
- R1: After the init sequence (0x11, base, 0x04, 0x01 to the primary at 0x20/0x21, and 0x11, base+8, 0x02, 0x01 to the secondary at 0xA0/0xA1), with no line raised, `cpu_irq` is low. In the init sequence a command byte with bit 4 set clears the mask and in-service state and starts the sequence; the next data-port byte supplies the vector base (its bits 2:0 are ignored).
- R2: Port 0x21/0xA1 reads back the mask last written after init. Ports 0x4D0/0x4D1 are read/write edge/level registers for primary/secondary, where bit n set means line n is level triggered.
- R3: Lines 0–7 belong to the primary and lines 8–15 to secondary line n−8. An acknowledged line returns the vector base | line.
- R4: A secondary request raises `cpu_irq`, and its acknowledge returns the secondary's vector. A lower-priority secondary line is served only after an EOI has been sent both to the secondary (its line) and to the primary (level 2).
- R5: An acknowledge while nothing is pending sets `ack_none`, and `ack_vec` = primary base | 7.
- R6: In edge mode, a line that stays high after being acknowledged does not request again. A new request needs the line to go low and then high.
- R7: In level mode, a line that is still high after its EOI requests again.
- R8: The lowest line number has priority. An in-service line blocks requests of equal and lower priority.
- R9: A command byte with bit 3 set and bit 4 clear selects what a command-port read returns: IRR if bit 1=1 and bit 0=0, ISR if bits 1:0=11, zero otherwise. A command byte with bits 4:3 = 00 and bit 7 = 0 is an EOI when bit 5 = 1. With bit 6 = 1 it clears the in-service bit named by bits 2:0; with bit 6 = 0 it clears the highest-priority in-service bit.
- R10: A 2-byte write (`wide`=1) to 0x20 sends `wdata[7:0]` to the primary and `wdata[15:8]` to the secondary. The same write to 0xA0 sends the bytes the other way round.
- R11: An unmapped port, a wide access to any port other than the two command ports, or any wide read answers `err`=1 and changes no state.
- R12: A masked line (mask bit set) does not drive `cpu_irq` until it is unmasked.
- R13: External input `irq_in[2]` has no effect.
- R14: `rdata`/`err` and `ack_valid`/`ack_vec`/`ack_none` appear exactly one cycle after the access or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 16 | Request lines, bit n is line n (bit 2 unused) |
| addr | input | 16 | Port address |
| wdata | input | 16 | Write data (high byte used only for wide writes) |
| wide | input | 1 | 1 = 2-byte access, 0 = 1-byte |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rdata | output | 8 | Read data, one cycle after `rd` |
| err | output | 1 | Error response, one cycle after the access |
| ack | input | 1 | CPU interrupt acknowledge pulse |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Returned vector |
| ack_none | output | 1 | No request was pending at acknowledge |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench checks that the cascaded path needs an EOI on both controllers. A design that released the secondary after only one EOI would raise `cpu_irq` too early. The split 16-bit command write is observed through the read-select registers of both controllers: if the swap on 0xA0 is missing, IRR and ISR trade places in the read-back. Edge-latch behaviour after an acknowledge, and nested in-service with non-specific EOI, show up as wrong vectors or a wrong ISR byte. Rejected wide writes to a data port are read back to prove that the mask did not change.

// File: rtl/dintc_pkg.sv
package dintc_pkg;
   typedef enum logic [2:0] {
      ST_RAW, ST_WAIT_BASE, ST_WAIT_CASC, ST_WAIT_MODE, ST_READY
   } init_e;

   // Index of the least-significant set bit; all-ones index when empty.
   function automatic logic [2:0] low_idx(input logic [7:0] v);
      logic [2:0] r;
      r = 3'd7;
      for (int i = 7; i >= 0; i--)
         if (v[i]) r = 3'(i);
      return r;
   endfunction
endpackage

// File: rtl/intc_core.sv
module intc_core
   import dintc_pkg::*;
#(
   parameter int         LINES      = 8,
   parameter logic [7:0] RESET_BASE = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_in,
   input  logic             cmd_we,
   input  logic             dat_we,
   input  logic             lvl_we,
   input  logic [7:0]       wbyte,
   input  logic             ack_en,
   output logic             pend,
   output logic [7:0]       vec,
   output logic [7:0]       cmd_rd,
   output logic [7:0]       imr_o,
   output logic [7:0]       lvl_o
);
   localparam int IDXW = $clog2(LINES);

   if (LINES != 8) begin : g_bad_lines
      $error("intc_core: vector format needs exactly 8 lines");
   end

   init_e            stage;
   logic [7:0]       base, imr, isr, lvl, low_latch;
   logic [1:0]       rsel;
   logic [7:0]       irr, lowest_isr, ready, ack_bit, isr_nx;
   logic [IDXW-1:0]  idx;

   assign irr        = line_in & (lvl | low_latch);
   assign lowest_isr = isr & (~isr + 8'd1);
   assign ready      = irr & ~imr & (lowest_isr - 8'd1);
   assign pend       = |ready;
   assign idx        = low_idx(ready);
   assign vec        = {base[7:3], pend ? idx : 3'd7};
   assign ack_bit    = (ack_en && pend) ? (8'd1 << idx) : 8'd0;
   assign imr_o      = imr;
   assign lvl_o      = lvl;
   assign cmd_rd     = !rsel[1] ? 8'd0 : (rsel[0] ? isr : irr);

   always_comb begin
      isr_nx = isr | ack_bit;
      if (cmd_we && wbyte[4:3] == 2'b00 && !wbyte[7] && wbyte[5]) begin
         if (wbyte[6]) isr_nx = isr_nx & ~(8'd1 << wbyte[2:0]);
         else          isr_nx = isr_nx & ~lowest_isr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage     <= ST_RAW;
         base      <= RESET_BASE;
         imr       <= '0;
         isr       <= '0;
         lvl       <= '0;
         low_latch <= '1;
         rsel      <= '0;
      end else if (cmd_we && wbyte[4]) begin
         stage     <= ST_WAIT_BASE;
         base      <= RESET_BASE;
         imr       <= '0;
         isr       <= '0;
         low_latch <= '1;
         rsel      <= '0;
      end else begin
         isr       <= isr_nx;
         low_latch <= (low_latch & ~ack_bit) | ~line_in;
         if (cmd_we && wbyte[3]) rsel <= wbyte[1:0];
         if (lvl_we) lvl <= wbyte;
         if (dat_we) begin
            unique case (stage)
               ST_WAIT_BASE: begin base <= {wbyte[7:3], 3'b000}; stage <= ST_WAIT_CASC; end
               ST_WAIT_CASC: stage <= ST_WAIT_MODE;
               ST_WAIT_MODE: stage <= ST_READY;
               default:      imr <= wbyte;
            endcase
         end
      end
   end
endmodule

// File: rtl/dintc_decode.sv
module dintc_decode #(
   parameter logic [15:0] PRI_CMD_ADDR = 16'h0020,
   parameter logic [15:0] PRI_DAT_ADDR = 16'h0021,
   parameter logic [15:0] SEC_CMD_ADDR = 16'h00A0,
   parameter logic [15:0] SEC_DAT_ADDR = 16'h00A1,
   parameter logic [15:0] PRI_LVL_ADDR = 16'h04D0,
   parameter logic [15:0] SEC_LVL_ADDR = 16'h04D1
) (
   input  logic [15:0] addr,
   input  logic        wide,
   input  logic        rd,
   input  logic        wr,
   output logic [1:0]  cmd_hit,
   output logic [1:0]  dat_hit,
   output logic [1:0]  lvl_hit,
   output logic        bad
);
   logic any_hit;

   assign cmd_hit = {addr == SEC_CMD_ADDR, addr == PRI_CMD_ADDR};
   assign dat_hit = {addr == SEC_DAT_ADDR, addr == PRI_DAT_ADDR};
   assign lvl_hit = {addr == SEC_LVL_ADDR, addr == PRI_LVL_ADDR};
   assign any_hit = |{cmd_hit, dat_hit, lvl_hit};
   assign bad     = !any_hit || (rd && wr) || (wide && !(wr && |cmd_hit));
endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
   parameter logic [15:0] PRI_CMD_ADDR = 16'h0020,
   parameter logic [15:0] PRI_DAT_ADDR = 16'h0021,
   parameter logic [15:0] SEC_CMD_ADDR = 16'h00A0,
   parameter logic [15:0] SEC_DAT_ADDR = 16'h00A1,
   parameter logic [15:0] PRI_LVL_ADDR = 16'h04D0,
   parameter logic [15:0] SEC_LVL_ADDR = 16'h04D1,
   parameter int          LINES        = 8,
   parameter int          CASCADE_LINE = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*LINES-1:0] irq_in,
   input  logic [15:0]        addr,
   input  logic [15:0]        wdata,
   input  logic               wide,
   input  logic               rd,
   input  logic               wr,
   output logic [7:0]         rdata,
   output logic               err,
   input  logic               ack,
   output logic               ack_valid,
   output logic [7:0]         ack_vec,
   output logic               ack_none,
   output logic               cpu_irq
);
   localparam int NCTL = 2;

   if (CASCADE_LINE < 0 || CASCADE_LINE >= LINES) begin : g_bad_casc
      $error("dual_intc: cascade line outside primary range");
   end

   logic [1:0]       cmd_hit, dat_hit, lvl_hit;
   logic             bad, ok_wr, ok_rd, chain;
   logic [NCTL-1:0]  pend, ack_en;
   logic [7:0]       vec    [NCTL];
   logic [7:0]       cmd_rd [NCTL];
   logic [7:0]       imr    [NCTL];
   logic [7:0]       lvl    [NCTL];
   logic [LINES-1:0] lines  [NCTL];
   logic [7:0]       rd_mux;

   dintc_decode #(
      .PRI_CMD_ADDR(PRI_CMD_ADDR), .PRI_DAT_ADDR(PRI_DAT_ADDR),
      .SEC_CMD_ADDR(SEC_CMD_ADDR), .SEC_DAT_ADDR(SEC_DAT_ADDR),
      .PRI_LVL_ADDR(PRI_LVL_ADDR), .SEC_LVL_ADDR(SEC_LVL_ADDR)
   ) u_dec (
      .addr(addr), .wide(wide), .rd(rd), .wr(wr),
      .cmd_hit(cmd_hit), .dat_hit(dat_hit), .lvl_hit(lvl_hit), .bad(bad)
   );

   assign ok_wr = wr && !bad;
   assign ok_rd = rd && !bad;

   // Primary acknowledged first; secondary only when the cascade line wins.
   assign chain     = ack && pend[0] && (vec[0][2:0] == 3'(CASCADE_LINE));
   assign ack_en[0] = ack;
   assign ack_en[1] = chain;
   assign cpu_irq   = pend[0];

   always_comb begin
      lines[0] = irq_in[LINES-1:0];
      lines[0][CASCADE_LINE] = pend[1];
      lines[1] = irq_in[2*LINES-1:LINES];
   end

   for (genvar g = 0; g < NCTL; g++) begin : g_ctl
      logic       c_we;
      logic [7:0] byte_g;
      // Wide write: low byte to the addressed controller, high byte to the other.
      assign c_we   = ok_wr && (wide ? 1'b1 : cmd_hit[g]);
      assign byte_g = (wide && ((g == 0) == cmd_hit[1])) ? wdata[15:8] : wdata[7:0];

      intc_core #(
         .LINES(LINES),
         .RESET_BASE(g == 0 ? 8'h00 : 8'h08)
      ) u_core (
         .clk(clk), .rst_n(rst_n), .line_in(lines[g]),
         .cmd_we(c_we), .dat_we(ok_wr && dat_hit[g]), .lvl_we(ok_wr && lvl_hit[g]),
         .wbyte(byte_g), .ack_en(ack_en[g]),
         .pend(pend[g]), .vec(vec[g]), .cmd_rd(cmd_rd[g]),
         .imr_o(imr[g]), .lvl_o(lvl[g])
      );
   end

   always_comb begin
      rd_mux = 8'd0;
      for (int i = 0; i < NCTL; i++) begin
         if (cmd_hit[i]) rd_mux = cmd_rd[i];
         if (dat_hit[i]) rd_mux = imr[i];
         if (lvl_hit[i]) rd_mux = lvl[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata     <= '0;
         err       <= 1'b0;
         ack_valid <= 1'b0;
         ack_vec   <= '0;
         ack_none  <= 1'b0;
      end else begin
         rdata     <= ok_rd ? rd_mux : 8'd0;
         err       <= (rd || wr) && bad;
         ack_valid <= ack;
         if (ack) begin
            ack_vec  <= chain ? vec[1] : vec[0];
            ack_none <= !pend[0];
         end
      end
   end
endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd,
   input logic       wr,
   input logic       wide,
   input logic       err,
   input logic       ack,
   input logic       ack_valid,
   input logic       ack_none,
   input logic [7:0] ack_vec
);
   assert_ack_resp_R14: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> ack_valid);
   assert_ack_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !ack_valid);
   assert_err_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd || wr) |=> !err);
   assert_wide_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && wide) |=> err);
   assert_none_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_none) |-> (ack_vec[2:0] == 3'd7));
endmodule

bind dual_intc dual_intc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .wide(wide), .err(err),
   .ack(ack), .ack_valid(ack_valid), .ack_none(ack_none), .ack_vec(ack_vec)
);

// File: tb/dual_intc_test.sv
module dual_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic [15:0] addr = '0;
   logic [15:0] wdata = '0;
   logic        wide = 1'b0, rd = 1'b0, wr = 1'b0, ack = 1'b0;
   logic [7:0]  rdata, ack_vec;
   logic        err, ack_valid, ack_none, cpu_irq;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   dual_intc uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wdata(wdata),
      .wide(wide), .rd(rd), .wr(wr), .rdata(rdata), .err(err), .ack(ack),
      .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_none(ack_none), .cpu_irq(cpu_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic w,
                         output logic e);
      @(negedge clk); addr = a; wdata = d; wide = w; wr = 1'b1;
      @(negedge clk); wr = 1'b0; wide = 1'b0; e = err;
   endtask

   task automatic wr8(input logic [15:0] a, input logic [7:0] d);
      logic e;
      bus_wr(a, {8'h00, d}, 1'b0, e);
   endtask

   task automatic bus_rd(input logic [15:0] a, input logic w, output logic [7:0] d,
                         output logic e);
      @(negedge clk); addr = a; wide = w; rd = 1'b1;
      @(negedge clk); rd = 1'b0; wide = 1'b0; d = rdata; e = err;
   endtask

   task automatic do_ack(output logic [7:0] v, output logic none, output logic vld);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; v = ack_vec; none = ack_none; vld = ack_valid;
   endtask

   task automatic set_irq(input int n, input logic val);
      @(negedge clk); irq_in[n] = val;
      @(negedge clk);
   endtask

   task automatic setup();
      irq_in = '0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      wr8(16'h20, 8'h11); wr8(16'h21, 8'h30); wr8(16'h21, 8'h04); wr8(16'h21, 8'h01);
      wr8(16'hA0, 8'h11); wr8(16'hA1, 8'h38); wr8(16'hA1, 8'h02); wr8(16'hA1, 8'h01);
   endtask

   task automatic t_init();
      logic [7:0] d; logic e;
      setup();
      chk("R1 cpu_irq low after init", cpu_irq, 0);
      bus_rd(16'h21, 1'b0, d, e);
      chk("R1 primary mask cleared", d, 0);
      wr8(16'h21, 8'h5A); bus_rd(16'h21, 1'b0, d, e);
      chk("R2 primary mask readback", d, 8'h5A);
      wr8(16'h4D1, 8'hC3); bus_rd(16'h4D1, 1'b0, d, e);
      chk("R2 secondary level register", d, 8'hC3);
      chk("R14 err low on valid read", e, 0);
   endtask

   task automatic t_edge_primary();
      logic [7:0] v; logic none, vld;
      setup();
      set_irq(4, 1'b1);
      chk("R3 line 4 raises cpu_irq", cpu_irq, 1);
      do_ack(v, none, vld);
      chk("R14 ack_valid one cycle later", vld, 1);
      chk("R3 primary vector", v, 8'h34);
      wr8(16'h20, 8'h64);
      chk("R6 held edge line does not re-request", cpu_irq, 0);
      do_ack(v, none, vld);
      chk("R5 none flag", none, 1);
      chk("R5 none vector", v, 8'h37);
      set_irq(4, 1'b0); set_irq(4, 1'b1);
      chk("R6 new edge requests again", cpu_irq, 1);
   endtask

   task automatic t_level();
      logic [7:0] v; logic none, vld;
      setup();
      wr8(16'h4D0, 8'h02);
      set_irq(1, 1'b1);
      do_ack(v, none, vld);
      chk("R7 level vector", v, 8'h31);
      wr8(16'h20, 8'h61);
      chk("R7 level line re-requests after EOI", cpu_irq, 1);
   endtask

   task automatic t_cascade();
      logic [7:0] v; logic none, vld;
      setup();
      set_irq(10, 1'b1);
      chk("R4 secondary raises cpu_irq", cpu_irq, 1);
      do_ack(v, none, vld);
      chk("R4 secondary vector", v, 8'h3A);
      set_irq(12, 1'b1);
      chk("R4 lower secondary blocked", cpu_irq, 0);
      wr8(16'hA0, 8'h62);
      chk("R4 still blocked after secondary EOI only", cpu_irq, 0);
      wr8(16'h20, 8'h62);
      chk("R4 released after both EOIs", cpu_irq, 1);
      do_ack(v, none, vld);
      chk("R4 second secondary vector", v, 8'h3C);
   endtask

   task automatic t_nested();
      logic [7:0] v; logic none, vld, e; logic [7:0] d;
      setup();
      irq_in[4] = 1'b1; irq_in[6] = 1'b1;
      do_ack(v, none, vld);
      chk("R8 lowest line wins", v, 8'h34);
      chk("R8 lower-priority line blocked by in-service", cpu_irq, 0);
      wr8(16'h20, 8'h64);
      do_ack(v, none, vld);
      chk("R8 next line after EOI", v, 8'h36);
      wr8(16'h20, 8'h66);
      irq_in = '0;
      set_irq(5, 1'b1); do_ack(v, none, vld);
      set_irq(3, 1'b1); do_ack(v, none, vld);
      set_irq(1, 1'b1); do_ack(v, none, vld);
      chk("R8 higher line preempts", v, 8'h31);
      wr8(16'h20, 8'h0B); bus_rd(16'h20, 1'b0, d, e);
      chk("R9 ISR readback", d, 8'h2A);
      wr8(16'h20, 8'h20); bus_rd(16'h20, 1'b0, d, e);
      chk("R9 non-specific EOI clears highest", d, 8'h28);
      wr8(16'h20, 8'h65); bus_rd(16'h20, 1'b0, d, e);
      chk("R9 specific EOI clears named level", d, 8'h08);
   endtask

   task automatic t_split();
      logic [7:0] v, d; logic none, vld, e;
      setup();
      set_irq(9, 1'b1); do_ack(v, none, vld);
      irq_in[0] = 1'b1;
      bus_wr(16'h20, 16'h0B0A, 1'b1, e);
      chk("R10 wide command write accepted", e, 0);
      bus_rd(16'h20, 1'b0, d, e);
      chk("R10 primary got low byte (IRR)", d, 8'h01);
      bus_rd(16'hA0, 1'b0, d, e);
      chk("R10 secondary got high byte (ISR)", d, 8'h02);
      bus_wr(16'hA0, 16'h0B0A, 1'b1, e);
      bus_rd(16'h20, 1'b0, d, e);
      chk("R10 swapped: primary got high byte (ISR)", d, 8'h04);
      bus_rd(16'hA0, 1'b0, d, e);
      chk("R10 swapped: secondary got low byte (IRR)", d, 8'h00);
   endtask

   task automatic t_errors_mask();
      logic [7:0] v, d; logic none, vld, e;
      setup();
      wr8(16'h21, 8'h02);
      bus_wr(16'h21, 16'h0000, 1'b1, e);
      chk("R11 wide data write errors", e, 1);
      bus_rd(16'h21, 1'b0, d, e);
      chk("R11 mask unchanged after rejected write", d, 8'h02);
      bus_wr(16'h22, 16'h0000, 1'b0, e);
      chk("R11 unmapped port errors", e, 1);
      bus_rd(16'h20, 1'b1, d, e);
      chk("R11 wide read errors", e, 1);
      set_irq(1, 1'b1);
      chk("R12 masked line silent", cpu_irq, 0);
      wr8(16'h21, 8'h00);
      chk("R12 unmasked line requests", cpu_irq, 1);
      irq_in[1] = 1'b0;
      set_irq(2, 1'b1);
      chk("R13 external line 2 ignored", cpu_irq, 0);
      do_ack(v, none, vld);
      chk("R13 ack with only line 2 reports none", none, 1);
   endtask

   initial begin
      t_init();
      t_edge_primary();
      t_level();
      t_cascade();
      t_nested();
      t_split();
      t_errors_mask();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule